// File: doc/BRIEF.md
# CAN Frame Download Command Handler

This block sits behind the receive and transmit frame ports of a CAN controller. It turns host command frames into writes to a code RAM window. Each received frame carries an 11-bit standard identifier, a data length code and up to eight payload bytes. The identifier selects one of four commands:

- set the load pointer;
- store payload bytes;
- compare a host checksum;
- start execution at an address.

The block keeps a running modulo-256 sum of the bytes it has stored. It answers a checksum command with a two-byte status frame. The pointer and the sum are both reset by every set-pointer frame. This lets a host resend a block, or load blocks that are not contiguous, and verify each one on its own.

A store frame is written out one byte per clock. While the writes run, the receive ready signal is held low. Nothing is accepted before the first valid set-pointer frame. Frames with an unknown identifier, or with too few bytes for their command, are dropped without side effects.

Top module: `canDlHandler`

## Requirements
- R1: After reset, rxReady is 1 and memWe, txReq and execStb are 0.
- R2: Until a valid set-pointer frame has been accepted, frames with ID 0x040, 0x080 and 0x010 cause no RAM write, no status frame and no execute strobe. Reset returns the block to this unarmed state.
- R3: A frame with ID 0x020 and length of at least 2 loads the write pointer. Payload byte 1 (rxData[7:0]) is the high byte and byte 2 (rxData[15:8]) is the low byte. The next stored byte goes to that address.
- R4: A frame with ID 0x040 and length n stores n bytes in byte order, one per clock. The bytes go to consecutive addresses starting at the pointer. The first write (memWe high) appears in the cycle after acceptance. Payload byte k is rxData[8k-1:8k-8].
- R5: A length code above 8 on an 0x040 frame is treated as 8.
- R6: rxReady is low for exactly n cycles after an n-byte store frame is accepted.
- R7: The running checksum is the modulo-256 sum of all bytes stored since the most recent set-pointer frame.
- R8: A frame with ID 0x080 and length of at least 1 produces a one-cycle txReq in the cycle after acceptance. The status frame has txId 0x600 and txLen 2. Its txData[7:0] is 0x80 if payload byte 1 equals the running checksum, and 0x01 otherwise. Its txData[15:8] is the running checksum.
- R9: A frame with ID 0x010 and length of at least 2 pulses execStb in the cycle after acceptance. execAddr is {byte 1, byte 2}.
- R10: Frames with any other ID, and 0x020/0x010 frames shorter than 2 bytes or 0x040/0x080 frames of length 0, change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received frame present |
| rxReady | output | 1 | Block can accept a frame this cycle |
| rxId | input | 11 | Standard frame identifier |
| rxLen | input | 4 | Data length code |
| rxData | input | 64 | Payload, byte 1 in bits 7:0 |
| memAddr | output | 16 | RAM write address |
| memData | output | 8 | RAM write data |
| memWe | output | 1 | RAM write strobe |
| txReq | output | 1 | One-cycle request to send the status frame |
| txId | output | 11 | Status frame identifier |
| txLen | output | 4 | Status frame length |
| txData | output | 16 | Status payload, byte 1 in bits 7:0 |
| execStb | output | 1 | One-cycle execute strobe |
| execAddr | output | 16 | Execute start address |

## Verification
The hardest state to reach is one where a malformed frame arrives while the block is armed and has a partly built checksum. Dropping that frame must leave the pointer and the sum untouched, and that can only be seen through later frames.

The stimulus table reaches this state with a fixed sequence:
1. Load some bytes.
2. Send a short set-pointer frame, an unknown identifier and zero-length store and checksum frames.
3. Store one more byte.
4. Request the checksum.

The address of the extra byte and the value of the reported sum then expose any disturbance. The over-long length code is reached the same way, and so is the checksum reset by a second set-pointer frame.

// File: rtl/canDlPkg.sv
package canDlPkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int ID_W    = 11;
  localparam int LEN_W   = 4;
  localparam int NBYTES  = 8;
  localparam int DATA_W  = NBYTES * BYTE_W;

  localparam logic [ID_W-1:0] ID_SETPTR = 11'h020;
  localparam logic [ID_W-1:0] ID_STORE  = 11'h040;
  localparam logic [ID_W-1:0] ID_CHECK  = 11'h080;
  localparam logic [ID_W-1:0] ID_EXEC   = 11'h010;
  localparam logic [ID_W-1:0] ID_STATUS = 11'h600;

  localparam logic [BYTE_W-1:0] SUM_OK  = 8'h80;
  localparam logic [BYTE_W-1:0] SUM_BAD = 8'h01;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_SETPTR, CMD_STORE, CMD_CHECK, CMD_EXEC
  } cmdT;

  typedef struct packed {
    logic loadPtr;
    logic startStore;
    logic writeByte;
    logic sendStatus;
    logic fireExec;
  } dlStrobeT;
endpackage

// File: rtl/canDlCtrl.sv
module canDlCtrl
  import canDlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [ID_W-1:0]  rxId,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             armed,
  input  logic             lastByte,
  output logic             rxReady,
  output logic             memWe,
  output dlStrobeT         stb
);
  typedef enum logic {S_IDLE, S_WRITE} stateT;
  stateT state, stateNext;

  cmdT  cmd;
  logic lenOk;
  logic accept;
  logic take;

  always_comb begin
    cmd   = CMD_NONE;
    lenOk = 1'b0;
    unique case (rxId)
      ID_SETPTR: begin cmd = CMD_SETPTR; lenOk = rxLen >= 4'd2; end
      ID_STORE:  begin cmd = CMD_STORE;  lenOk = rxLen >= 4'd1; end
      ID_CHECK:  begin cmd = CMD_CHECK;  lenOk = rxLen >= 4'd1; end
      ID_EXEC:   begin cmd = CMD_EXEC;   lenOk = rxLen >= 4'd2; end
      default:   begin cmd = CMD_NONE;   lenOk = 1'b0; end
    endcase
  end

  assign rxReady = (state == S_IDLE);
  assign accept  = rxValid && rxReady;
  assign take    = accept && lenOk && (cmd != CMD_NONE) && (armed || cmd == CMD_SETPTR);
  assign memWe   = (state == S_WRITE);

  always_comb begin
    stb            = '0;
    stb.loadPtr    = take && (cmd == CMD_SETPTR);
    stb.startStore = take && (cmd == CMD_STORE);
    stb.sendStatus = take && (cmd == CMD_CHECK);
    stb.fireExec   = take && (cmd == CMD_EXEC);
    stb.writeByte  = (state == S_WRITE);
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (stb.startStore) stateNext = S_WRITE;
      S_WRITE: if (lastByte)       stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R2
  no_unarmed_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !memWe);

  // R10
  drop_unknown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmd == CMD_NONE) |=> rxReady);
endmodule

// File: rtl/canDlDatapath.sv
module canDlDatapath
  import canDlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dlStrobeT          stb,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic [DATA_W-1:0] rxData,
  output logic              armed,
  output logic              lastByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData,
  output logic              txReq,
  output logic [BYTE_W-1:0] txCode,
  output logic [BYTE_W-1:0] txSum,
  output logic              execStb,
  output logic [ADDR_W-1:0] execAddr
);
  localparam int CNT_W = $clog2(NBYTES + 1);

  logic [BYTE_W-1:0] rxByte  [NBYTES];
  logic [BYTE_W-1:0] pending [NBYTES];
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] csum;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  lenClamp;

  for (genvar i = 0; i < NBYTES; i++) begin : g_unpack
    assign rxByte[i] = rxData[i*BYTE_W +: BYTE_W];
  end

  assign lenClamp = (rxLen > LEN_W'(NBYTES)) ? CNT_W'(NBYTES) : CNT_W'(rxLen);

  for (genvar i = 0; i < NBYTES; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rstN)               pending[i] <= '0;
      else if (stb.startStore) pending[i] <= rxByte[i];
      else if (stb.writeByte)  pending[i] <= (i == NBYTES - 1) ? '0 : pending[(i + 1) % NBYTES];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0; csum <= '0; remain <= '0; armed <= 1'b0;
      txReq <= 1'b0; txCode <= '0; txSum <= '0;
      execStb <= 1'b0; execAddr <= '0;
    end else begin
      txReq   <= stb.sendStatus;
      execStb <= stb.fireExec;
      if (stb.loadPtr) begin
        ptr   <= {rxByte[0], rxByte[1]};
        csum  <= '0;
        armed <= 1'b1;
      end
      if (stb.startStore) remain <= lenClamp;
      if (stb.writeByte) begin
        ptr    <= ptr + 1'b1;
        csum   <= csum + pending[0];
        remain <= remain - 1'b1;
      end
      if (stb.sendStatus) begin
        txCode <= (csum == rxByte[0]) ? SUM_OK : SUM_BAD;
        txSum  <= csum;
      end
      if (stb.fireExec) execAddr <= {rxByte[0], rxByte[1]};
    end
  end

  assign lastByte = (remain == CNT_W'(1));
  assign memAddr  = ptr;
  assign memData  = pending[0];

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadPtr |=> ptr == {$past(rxByte[0]), $past(rxByte[1])});

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R7
  sum_accum_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |=> csum == BYTE_W'($past(csum) + $past(pending[0])));

  // R8
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (txCode == SUM_OK || txCode == SUM_BAD));

  // R9
  exec_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fireExec |=> execStb && execAddr == {$past(rxByte[0]), $past(rxByte[1])});
endmodule

// File: rtl/canDlHandler.sv
module canDlHandler
  import canDlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [ID_W-1:0]   rxId,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic [DATA_W-1:0] rxData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData,
  output logic              memWe,
  output logic              txReq,
  output logic [ID_W-1:0]   txId,
  output logic [LEN_W-1:0]  txLen,
  output logic [2*BYTE_W-1:0] txData,
  output logic              execStb,
  output logic [ADDR_W-1:0] execAddr
);
  dlStrobeT stb;
  logic armed, lastByte;
  logic [BYTE_W-1:0] txCode, txSum;

  canDlCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxId(rxId), .rxLen(rxLen),
    .armed(armed), .lastByte(lastByte), .rxReady(rxReady), .memWe(memWe), .stb(stb)
  );

  canDlDatapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxLen(rxLen), .rxData(rxData),
    .armed(armed), .lastByte(lastByte), .memAddr(memAddr), .memData(memData),
    .txReq(txReq), .txCode(txCode), .txSum(txSum),
    .execStb(execStb), .execAddr(execAddr)
  );

  assign txId   = ID_STATUS;
  assign txLen  = LEN_W'(2);
  assign txData = {txSum, txCode};
endmodule

// File: tb/canDlHandler_test.sv
`timescale 1ns/1ps
module canDlHandler_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic rxReady;
  logic [10:0] rxId = '0;
  logic [3:0]  rxLen = '0;
  logic [63:0] rxData = '0;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic memWe, txReq, execStb;
  logic [10:0] txId;
  logic [3:0]  txLen;
  logic [15:0] txData, execAddr;

  always #2.5 clk = ~clk;

  canDlHandler uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxReady(rxReady), .rxId(rxId),
    .rxLen(rxLen), .rxData(rxData), .memAddr(memAddr), .memData(memData), .memWe(memWe),
    .txReq(txReq), .txId(txId), .txLen(txLen), .txData(txData),
    .execStb(execStb), .execAddr(execAddr)
  );

  typedef struct packed {
    logic [10:0] id; logic [3:0] len; logic [63:0] data;
    logic [3:0] nWr; logic [15:0] base;
    logic txE; logic [7:0] t1; logic [7:0] t2;
    logic exE; logic [15:0] exA;
  } vecT;

  localparam int NV = 19;
  localparam vecT VEC [NV] = '{
    '{11'h040, 4'd2, 64'h2211, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R2 store before arm
    '{11'h080, 4'd1, 64'h00,   4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R2 check before arm
    '{11'h010, 4'd2, 64'h0040, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R2 exec before arm
    '{11'h020, 4'd2, 64'h3412, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R3 pointer 0x1234
    '{11'h040, 4'd3, 64'h030201, 4'd3, 16'h1234, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},          // R4 three bytes
    '{11'h040, 4'd1, 64'hFF,   4'd1, 16'h1237, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},            // R4 continues
    '{11'h080, 4'd1, 64'h05,   4'd0, 16'h0, 1'b1, 8'h80, 8'h05, 1'b0, 16'h0},               // R7 sum wraps to 0x05
    '{11'h080, 4'd1, 64'h06,   4'd0, 16'h0, 1'b1, 8'h01, 8'h05, 1'b0, 16'h0},               // R8 mismatch
    '{11'h123, 4'd8, 64'h1122334455667788, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},  // R10 unknown id
    '{11'h020, 4'd1, 64'h77,   4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R10 short setptr
    '{11'h040, 4'd1, 64'hAA,   4'd1, 16'h1238, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},            // R10 pointer kept
    '{11'h040, 4'd0, 64'h99,   4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R10 empty store
    '{11'h080, 4'd0, 64'h00,   4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R10 empty check
    '{11'h080, 4'd1, 64'hAF,   4'd0, 16'h0, 1'b1, 8'h80, 8'hAF, 1'b0, 16'h0},               // R7 sum kept 0xAF
    '{11'h020, 4'd2, 64'h0020, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0},               // R3 pointer 0x2000
    '{11'h040, 4'd15, 64'h0807060504030201, 4'd8, 16'h2000, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0}, // R5 clamp
    '{11'h080, 4'd1, 64'h00,   4'd0, 16'h0, 1'b1, 8'h01, 8'h24, 1'b0, 16'h0},               // R7 cleared then 0x24
    '{11'h010, 4'd2, 64'h0080, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b1, 16'h8000},            // R9 execute
    '{11'h010, 4'd1, 64'h0090, 4'd0, 16'h0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0}                // R10 short exec
  };

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int accCyc = 0;
  bit prevReady = 1'b0;
  int busy = 0;
  int wrC = 0;
  logic [15:0] wrA [16];
  logic [7:0]  wrD [16];
  int wrT [16];
  int txC = 0;
  int txT = 0;
  logic [30:0] txCap;
  int exC = 0;
  int exT = 0;
  logic [15:0] exCap;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rxValid && prevReady) accCyc = cyc;
    prevReady = rxReady;
    if (!rxReady) busy++;
    if (memWe) begin
      if (wrC < 16) begin wrA[wrC] = memAddr; wrD[wrC] = memData; wrT[wrC] = cyc; end
      wrC++;
    end
    if (txReq) begin txC++; txT = cyc; txCap = {txId, txLen, txData}; end
    if (execStb) begin exC++; exT = cyc; exCap = execAddr; end
  end

  task automatic sendFrame(input logic [10:0] id, input logic [3:0] len, input logic [63:0] d);
    @(negedge clk);
    while (!rxReady) @(negedge clk);
    #1;
    busy = 0; wrC = 0; txC = 0; exC = 0;
    rxId = id; rxLen = len; rxData = d; rxValid = 1'b1;
    @(negedge clk);
    #1;
    rxValid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rxReady == 1'b1, "R1 rxReady", rxReady, 1);
    chk(memWe == 1'b0, "R1 memWe", memWe, 0);
    chk(txReq == 1'b0, "R1 txReq", txReq, 0);
    chk(execStb == 1'b0, "R1 execStb", execStb, 0);
    #1 rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      sendFrame(VEC[v].id, VEC[v].len, VEC[v].data);
      // R4 write count, addresses, data and timing
      chk(wrC == int'(VEC[v].nWr), $sformatf("R4 write count vec %0d", v), wrC, VEC[v].nWr);
      for (int i = 0; i < int'(VEC[v].nWr) && i < wrC; i++) begin
        chk(wrA[i] == VEC[v].base + 16'(i), $sformatf("R4 addr vec %0d byte %0d", v, i), wrA[i], VEC[v].base + 16'(i));
        chk(wrD[i] == VEC[v].data[i*8 +: 8], $sformatf("R4 data vec %0d byte %0d", v, i), wrD[i], VEC[v].data[i*8 +: 8]);
        chk(wrT[i] == accCyc + i, $sformatf("R4 cycle vec %0d byte %0d", v, i), wrT[i], accCyc + i);
      end
      // R6 ready held low for the store
      chk(busy == int'(VEC[v].nWr), $sformatf("R6 busy cycles vec %0d", v), busy, VEC[v].nWr);
      // R8 status frame
      chk(txC == int'(VEC[v].txE), $sformatf("R8 status count vec %0d", v), txC, VEC[v].txE);
      if (VEC[v].txE && txC == 1) begin
        chk(txCap == {11'h600, 4'd2, VEC[v].t2, VEC[v].t1}, $sformatf("R8 status frame vec %0d", v),
            txCap, {11'h600, 4'd2, VEC[v].t2, VEC[v].t1});
        chk(txT == accCyc, $sformatf("R8 status cycle vec %0d", v), txT, accCyc);
      end
      // R9 execute strobe
      chk(exC == int'(VEC[v].exE), $sformatf("R9 exec count vec %0d", v), exC, VEC[v].exE);
      if (VEC[v].exE && exC == 1) begin
        chk(exCap == VEC[v].exA, $sformatf("R9 exec addr vec %0d", v), exCap, VEC[v].exA);
        chk(exT == accCyc, $sformatf("R9 exec cycle vec %0d", v), exT, accCyc);
      end
    end

    // R2 reset disarms: a store after reset writes nothing
    @(negedge clk); #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(rxReady == 1'b1 && memWe == 1'b0, "R1 reset again", {rxReady, memWe}, 2'b10);
    #1 rstN = 1'b1;
    sendFrame(11'h040, 4'd4, 64'h44332211);
    chk(wrC == 0, "R2 store after reset", wrC, 0);
    sendFrame(11'h080, 4'd1, 64'h00);
    chk(txC == 0, "R2 check after reset", txC, 0);

    // R3 R7 rearm with 0x00FF, two bytes, checksum 0x10+0xF0 = 0x00
    sendFrame(11'h020, 4'd2, 64'hFF00);
    sendFrame(11'h040, 4'd2, 64'hF010);
    chk(wrC == 2 && wrA[0] == 16'h00FF && wrA[1] == 16'h0100, "R3 pointer carry", {wrA[0], wrA[1]}, 32'h00FF0100);
    sendFrame(11'h080, 4'd1, 64'h00);
    chk(txC == 1 && txCap[15:0] == 16'h0080, "R7 wrapped zero sum", txCap[15:0], 16'h0080);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule